// File: doc/BRIEF.md
# Status Word and Banked Stack-Pointer Register Unit

This unit holds the architectural register state of a small 32-bit processor core. That state is sixteen general registers, two shadow stack pointers (user and system) and four plain dedicated registers: table base, return pointer, multiply high and multiply low. It also holds a processor status word made of three fields. The first is a condition field, which carries the arithmetic flags, the interrupt enable and the stack-select flag. The second is a system-control field, which carries the step-trace flag and two divide flags. The third is an interrupt level mask.

General register r15 is always the live stack pointer. The stack-select flag decides which shadow pointer r15 stands for. When software changes that flag, the unit moves r15 into the shadow pointer being retired and loads r15 from the one being activated, all in the same clock edge. Accesses to the shadow pointer that is currently live are steered to r15. A write to the interrupt level mask cannot drop the level from the upper half (16 to 31) into the lower half.

The unit has one synchronous write port, a combinational read port and a dedicated output that always presents the composed status word. A selector code picks the target of a write or read.

Top module: `psw_bank_unit`

## Requirements
- R1: While reset (`rstN` low, active low) is applied and after it is released, every register reads zero except the interrupt level mask, which reads 15. `statusWord` is therefore 0x000F0000 and stack select is 0.
- R2: Selector codes are: 0 general register `rdIdx`/`wrIdx`, 1 user stack pointer, 2 system stack pointer, 3 table base, 4 return pointer, 5 multiply high, 6 multiply low, 7 condition field, 8 system-control field, 9 interrupt level mask, 10 full status word. General and dedicated registers (codes 0 and 3 to 6) store `wrData` on a clock edge with `wrEn` high and read it back unchanged.
- R3: A write with code 7 stores `wrData[5:0]` into the condition field. The field holds carry (bit 0), overflow (bit 1), zero (bit 2), negative (bit 3), interrupt enable (bit 4) and stack select (bit 5). Higher bits are discarded.
- R4: A write with code 8 stores `wrData[2:0]` into the system-control field, which holds step-trace (bit 0), divide flag 0 (bit 1) and divide flag 1 (bit 2).
- R5: A write with code 9 takes the 5-bit value `wrData[4:0]`. If the current mask is 16 or more and that value is below 16, the mask becomes the value plus 16. Otherwise the mask becomes the value.
- R6: A write with code 10 updates all three fields in one edge. The condition field comes from `wrData[5:0]`, the system-control field from `wrData[10:8]` and the mask from `wrData[20:16]`. Each field follows its own rule, including R5 and the swaps of R7 and R8.
- R7: When a write moves stack select from 0 to 1, the old r15 goes to the system stack pointer and r15 takes the old user stack pointer.
- R8: When a write moves stack select from 1 to 0, the old r15 goes to the user stack pointer and r15 takes the old system stack pointer.
- R9: Writing stack select with its current value moves no register.
- R10: While stack select is 0, reads and writes with code 2 access r15. While stack select is 1, reads and writes with code 1 access r15. Otherwise codes 1 and 2 access their own shadow register.
- R11: `statusWord` places the condition field in bits 7:0, the system-control field in bits 10:8 and the mask in bits 20:16. Bits 7:6, 15:11 and 31:21 are zero. Read codes 7, 8 and 9 return their field zero-extended, and read code 10 returns `statusWord`.
- R12: A write with `wrEn` low, or with a selector code of 11 to 15, changes no register. Reads with codes 11 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Write strobe |
| wrSel | input | 4 | Write target selector code |
| wrIdx | input | 4 | General register index for selector 0 |
| wrData | input | 32 | Write data |
| rdSel | input | 4 | Read selector code |
| rdIdx | input | 4 | General register index for read selector 0 |
| rdData | output | 32 | Combinational read data |
| statusWord | output | 32 | Composed status word |

## Verification
Directed sequences first fill r15 and both shadow pointers with distinct values. They then flip stack select in both directions, and also rewrite it with its existing value, so that a swap taken the wrong way round, a missed swap or a spurious swap each shows up as a specific wrong pointer. Mask writes step through values on both sides of 16, starting from both a low and a high current level, to separate a missing floor from a floor applied in the wrong direction. Full-word writes with all bits set exercise field splitting and reserved-bit clearing together. A long random sequence over every selector code, including the undefined ones, is then checked against a behavioural model on every clock.

// File: rtl/psw_bank_pkg.sv
package psw_bank_pkg;

  localparam int COND_W    = 6;
  localparam int SYS_W     = 3;
  localparam int ILM_W     = 5;
  localparam int SYS_LSB   = 8;
  localparam int ILM_LSB   = 16;
  localparam int STACK_BIT = 5;
  localparam int DED_NUM   = 4;
  localparam int DED_TBR   = 0;
  localparam int DED_RP    = 1;
  localparam int DED_MDH   = 2;
  localparam int DED_MDL   = 3;
  localparam logic [ILM_W-1:0] ILM_RESET = 5'd15;
  localparam logic [ILM_W-1:0] ILM_FLOOR = 5'd16;

  typedef enum logic [3:0] {
    SEL_GR   = 4'd0,
    SEL_USP  = 4'd1,
    SEL_SSP  = 4'd2,
    SEL_TBR  = 4'd3,
    SEL_RP   = 4'd4,
    SEL_MDH  = 4'd5,
    SEL_MDL  = 4'd6,
    SEL_COND = 4'd7,
    SEL_SYS  = 4'd8,
    SEL_ILM  = 4'd9,
    SEL_PSW  = 4'd10
  } sel_e;

  typedef struct packed {
    logic               grWe;
    logic               spWe;
    logic               uspWe;
    logic               sspWe;
    logic [DED_NUM-1:0] dedWe;
    logic               condWe;
    logic               sysWe;
    logic               ilmWe;
    logic [SYS_W-1:0]   sysVal;
    logic [ILM_W-1:0]   ilmVal;
    logic               toUser;
    logic               toSys;
  } strobe_t;

endpackage

// File: rtl/psw_bank_ctrl.sv
module psw_bank_ctrl
  import psw_bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              wrEn,
  input  logic [3:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              stackSel,
  input  logic [ILM_W-1:0]  ilmCur,
  output strobe_t           stb
);

  logic [ILM_W-1:0] ilmSrc;
  logic             newStack;

  always_comb begin
    stb      = '0;
    ilmSrc   = ilmCur;
    newStack = stackSel;
    if (wrEn) begin
      case (wrSel)
        SEL_GR:  stb.grWe = 1'b1;
        SEL_USP: begin
          if (stackSel) stb.spWe  = 1'b1;
          else          stb.uspWe = 1'b1;
        end
        SEL_SSP: begin
          if (!stackSel) stb.spWe  = 1'b1;
          else           stb.sspWe = 1'b1;
        end
        SEL_TBR: stb.dedWe[DED_TBR] = 1'b1;
        SEL_RP:  stb.dedWe[DED_RP]  = 1'b1;
        SEL_MDH: stb.dedWe[DED_MDH] = 1'b1;
        SEL_MDL: stb.dedWe[DED_MDL] = 1'b1;
        SEL_COND: begin
          stb.condWe = 1'b1;
          newStack   = wrData[STACK_BIT];
        end
        SEL_SYS: begin
          stb.sysWe  = 1'b1;
          stb.sysVal = wrData[SYS_W-1:0];
        end
        SEL_ILM: begin
          stb.ilmWe = 1'b1;
          ilmSrc    = wrData[ILM_W-1:0];
        end
        SEL_PSW: begin
          stb.condWe = 1'b1;
          newStack   = wrData[STACK_BIT];
          stb.sysWe  = 1'b1;
          stb.sysVal = wrData[SYS_LSB +: SYS_W];
          stb.ilmWe  = 1'b1;
          ilmSrc     = wrData[ILM_LSB +: ILM_W];
        end
        default: ;
      endcase
    end
    // the mask cannot leave the upper half through a write
    if ((ilmCur >= ILM_FLOOR) && (ilmSrc < ILM_FLOOR))
      stb.ilmVal = ilmSrc + ILM_FLOOR;
    else
      stb.ilmVal = ilmSrc;
    stb.toUser = stb.condWe & ~stackSel & newStack;
    stb.toSys  = stb.condWe & stackSel & ~newStack;
  end

endmodule

// File: rtl/psw_bank_dp.sv
module psw_bank_dp
  import psw_bank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int GR_NUM = 16,
  localparam int IDX_W = $clog2(GR_NUM),
  localparam int SP_IDX = GR_NUM - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [3:0]        rdSel,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] statusWord,
  output logic              stackSel,
  output logic [ILM_W-1:0]  ilmCur
);

  logic [DATA_W-1:0] grQ  [GR_NUM];
  logic [DATA_W-1:0] dedQ [DED_NUM];
  logic [DATA_W-1:0] uspQ, sspQ;
  logic [COND_W-1:0] condQ;
  logic [SYS_W-1:0]  sysQ;
  logic [ILM_W-1:0]  ilmQ;

  assign stackSel = condQ[STACK_BIT];
  assign ilmCur   = ilmQ;

  // general registers and the banked stack pointers; a swap is applied last
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < GR_NUM; i++) grQ[i] <= '0;
      uspQ <= '0;
      sspQ <= '0;
    end else begin
      for (int i = 0; i < GR_NUM; i++)
        if (stb.grWe && (wrIdx == IDX_W'(i))) grQ[i] <= wrData;
      if (stb.spWe)  grQ[SP_IDX] <= wrData;
      if (stb.uspWe) uspQ <= wrData;
      if (stb.sspWe) sspQ <= wrData;
      if (stb.toUser) begin
        sspQ        <= grQ[SP_IDX];
        grQ[SP_IDX] <= uspQ;
      end
      if (stb.toSys) begin
        uspQ        <= grQ[SP_IDX];
        grQ[SP_IDX] <= sspQ;
      end
    end
  end

  for (genvar k = 0; k < DED_NUM; k++) begin : g_ded
    always_ff @(posedge clk) begin
      if (!rstN)              dedQ[k] <= '0;
      else if (stb.dedWe[k])  dedQ[k] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      condQ <= '0;
      sysQ  <= '0;
      ilmQ  <= ILM_RESET;
    end else begin
      if (stb.condWe) condQ <= wrData[COND_W-1:0];
      if (stb.sysWe)  sysQ  <= stb.sysVal;
      if (stb.ilmWe)  ilmQ  <= stb.ilmVal;
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[COND_W-1:0]        = condQ;
    statusWord[SYS_LSB +: SYS_W]  = sysQ;
    statusWord[ILM_LSB +: ILM_W]  = ilmQ;
  end

  always_comb begin
    case (rdSel)
      SEL_GR:   rdData = grQ[rdIdx];
      SEL_USP:  rdData = stackSel ? grQ[SP_IDX] : uspQ;
      SEL_SSP:  rdData = stackSel ? sspQ : grQ[SP_IDX];
      SEL_TBR:  rdData = dedQ[DED_TBR];
      SEL_RP:   rdData = dedQ[DED_RP];
      SEL_MDH:  rdData = dedQ[DED_MDH];
      SEL_MDL:  rdData = dedQ[DED_MDL];
      SEL_COND: rdData = DATA_W'(condQ);
      SEL_SYS:  rdData = DATA_W'(sysQ);
      SEL_ILM:  rdData = DATA_W'(ilmQ);
      SEL_PSW:  rdData = statusWord;
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/psw_bank_unit.sv
module psw_bank_unit
  import psw_bank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int GR_NUM = 16,
  localparam int IDX_W = $clog2(GR_NUM)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [3:0]        wrSel,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [3:0]        rdSel,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] statusWord
);

  strobe_t          stb;
  logic             stackSel;
  logic [ILM_W-1:0] ilmCur;

  psw_bank_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrData   (wrData),
    .stackSel (stackSel),
    .ilmCur   (ilmCur),
    .stb      (stb)
  );

  psw_bank_dp #(.DATA_W(DATA_W), .GR_NUM(GR_NUM)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrIdx      (wrIdx),
    .wrData     (wrData),
    .rdSel      (rdSel),
    .rdIdx      (rdIdx),
    .rdData     (rdData),
    .statusWord (statusWord),
    .stackSel   (stackSel),
    .ilmCur     (ilmCur)
  );

endmodule

// File: rtl/psw_bank_chk.sv
module psw_bank_chk
  import psw_bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [3:0]        wrSel,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] statusWord
);

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[DATA_W-1:21] == '0) && (statusWord[15:11] == '0) && (statusWord[7:6] == '0)); // R11

  AST_COND_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == SEL_COND) |=> (statusWord[5:0] == $past(wrData[5:0]))); // R3

  AST_SYS_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == SEL_SYS) |=> (statusWord[10:8] == $past(wrData[2:0]))); // R4

  AST_ILM_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == SEL_ILM && statusWord[20]) |=> statusWord[20]); // R5

  AST_ILM_FROM_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == SEL_ILM && !statusWord[20]) |=> (statusWord[20:16] == $past(wrData[4:0]))); // R5

  AST_PSW_SPLIT: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == SEL_PSW) |=>
      (statusWord[10:0] == {$past(wrData[10:8]), 2'b00, $past(wrData[5:0])})); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn) |=> $stable(statusWord)); // R12

endmodule

bind psw_bank_unit psw_bank_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrSel      (wrSel),
  .wrData     (wrData),
  .statusWord (statusWord)
);

// File: tb/psw_bank_unit_bench.sv
module psw_bank_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrSel = '0, wrIdx = '0, rdSel = '0, rdIdx = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData, statusWord;

  int unsigned nCmp = 0;
  int unsigned nBad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  psw_bank_unit u_psw_bank_unit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrIdx(wrIdx),
    .wrData(wrData), .rdSel(rdSel), .rdIdx(rdIdx), .rdData(rdData),
    .statusWord(statusWord)
  );

  // behavioural model state
  logic [31:0] mGr [16];
  logic [31:0] mDed [4];
  logic [31:0] mUsp, mSsp;
  int          mCond, mSys, mIlm;

  task automatic modelReset();
    for (int i = 0; i < 16; i++) mGr[i] = '0;
    for (int i = 0; i < 4; i++) mDed[i] = '0;
    mUsp = '0; mSsp = '0; mCond = 0; mSys = 0; mIlm = 15;
  endtask

  function automatic int mStack();
    return (mCond >> 5) & 1;
  endfunction

  function automatic logic [31:0] mPsw();
    return 32'(mCond) | (32'(mSys) << 8) | (32'(mIlm) << 16);
  endfunction

  function automatic logic [31:0] mRead(int sel, int idx);
    case (sel)
      0: return mGr[idx];
      1: return (mStack() == 1) ? mGr[15] : mUsp;
      2: return (mStack() == 0) ? mGr[15] : mSsp;
      3, 4, 5, 6: return mDed[sel - 3];
      7: return 32'(mCond);
      8: return 32'(mSys);
      9: return 32'(mIlm);
      10: return mPsw();
      default: return '0;
    endcase
  endfunction

  task automatic mSetCond(int v);
    int oldS;
    int newS;
    logic [31:0] sp;
    oldS = mStack();
    newS = (v >> 5) & 1;
    mCond = v;
    sp = mGr[15];
    if (oldS == 0 && newS == 1) begin mSsp = sp; mGr[15] = mUsp; end
    if (oldS == 1 && newS == 0) begin mUsp = sp; mGr[15] = mSsp; end
  endtask

  task automatic mSetIlm(int v);
    int nv;
    nv = v;
    if (mIlm >= 16 && nv < 16) nv = nv + 16;
    mIlm = nv;
  endtask

  task automatic mWrite(int sel, int idx, logic [31:0] d);
    case (sel)
      0: mGr[idx] = d;
      1: if (mStack() == 1) mGr[15] = d; else mUsp = d;
      2: if (mStack() == 0) mGr[15] = d; else mSsp = d;
      3, 4, 5, 6: mDed[sel - 3] = d;
      7: mSetCond(int'(d & 32'h3F));
      8: mSys = int'(d & 32'h7);
      9: mSetIlm(int'(d & 32'h1F));
      10: begin
        mSetCond(int'(d & 32'h3F));
        mSys = int'((d >> 8) & 32'h7);
        mSetIlm(int'((d >> 16) & 32'h1F));
      end
      default: ;
    endcase
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle, compare outputs against the model, then advance the model
  task automatic step(bit we, int sel, int idx, logic [31:0] d, int rs, int ri, string tag);
    @(negedge clk);
    wrEn = we; wrSel = sel[3:0]; wrIdx = idx[3:0]; wrData = d;
    rdSel = rs[3:0]; rdIdx = ri[3:0];
    #1;
    check(tag, rdData, mRead(rs, ri));
    check(tag, statusWord, mPsw());
    @(posedge clk);
    if (we) mWrite(sel, idx, d);
  endtask

  task automatic sweep(string tag);
    for (int s = 0; s < 16; s++)
      if (s == 0) for (int i = 0; i < 16; i++) step(1'b0, 0, 0, '0, 0, i, tag);
      else step(1'b0, 0, 0, '0, s, 0, tag);
  endtask

  task automatic expectRead(int rs, int ri, logic [31:0] exp, string tag);
    @(negedge clk);
    wrEn = 1'b0; rdSel = rs[3:0]; rdIdx = ri[3:0];
    #1;
    check(tag, rdData, exp);
  endtask

  function automatic string tagFor(int sel);
    case (sel)
      0, 3, 4, 5, 6: return "R2";
      1, 2: return "R10";
      7: return "R3";
      8: return "R4";
      9: return "R5";
      10: return "R6";
      default: return "R12";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check("R1", statusWord, 32'h000F_0000);
    rstN = 1'b1;
    sweep("R1");

    // R2: plain storage
    for (int i = 0; i < 16; i++) step(1'b1, 0, i, 32'hA500_0000 + 32'(i * 17), 0, i, "R2");
    for (int s = 3; s <= 6; s++) step(1'b1, s, 0, 32'h1234_5670 + 32'(s), s, 0, "R2");
    sweep("R2");

    // R3, R4: field masking
    step(1'b1, 7, 0, 32'hFFFF_FFDF, 7, 0, "R3");
    expectRead(7, 0, 32'h0000_001F, "R3");
    step(1'b1, 8, 0, 32'hFFFF_FFFD, 8, 0, "R4");
    expectRead(8, 0, 32'h0000_0005, "R4");
    expectRead(10, 0, 32'h000F_051F, "R11");

    // R10, R7, R8, R9: banking
    step(1'b1, 0, 15, 32'h0000_AAAA, 0, 15, "R10");
    step(1'b1, 1, 0, 32'h0000_BBBB, 1, 0, "R10");
    expectRead(2, 0, 32'h0000_AAAA, "R10");
    step(1'b1, 7, 0, 32'h0000_0020, 0, 15, "R7");
    expectRead(0, 15, 32'h0000_BBBB, "R7");
    expectRead(2, 0, 32'h0000_AAAA, "R7");
    expectRead(1, 0, 32'h0000_BBBB, "R10");
    step(1'b1, 7, 0, 32'h0000_0021, 0, 15, "R9");
    expectRead(0, 15, 32'h0000_BBBB, "R9");
    expectRead(2, 0, 32'h0000_AAAA, "R9");
    step(1'b1, 0, 15, 32'h0000_CCCC, 0, 15, "R10");
    step(1'b1, 2, 0, 32'h0000_DDDD, 2, 0, "R10");
    step(1'b1, 7, 0, 32'h0000_0000, 0, 15, "R8");
    expectRead(0, 15, 32'h0000_DDDD, "R8");
    expectRead(1, 0, 32'h0000_CCCC, "R8");
    step(1'b1, 7, 0, 32'h0000_0001, 0, 15, "R9");
    expectRead(0, 15, 32'h0000_DDDD, "R9");

    // R5: mask floor
    step(1'b1, 9, 0, 32'h0000_0003, 9, 0, "R5");
    expectRead(9, 0, 32'h0000_0003, "R5");
    step(1'b1, 9, 0, 32'h0000_0014, 9, 0, "R5");
    step(1'b1, 9, 0, 32'h0000_0005, 9, 0, "R5");
    expectRead(9, 0, 32'h0000_0015, "R5");
    step(1'b1, 9, 0, 32'h0000_0010, 9, 0, "R5");
    expectRead(9, 0, 32'h0000_0010, "R5");

    // R6: full word
    step(1'b1, 10, 0, 32'hFFFF_FFFF, 10, 0, "R6");
    expectRead(10, 0, 32'h001F_073F, "R6");
    step(1'b1, 10, 0, 32'h0002_0000, 10, 0, "R6");
    expectRead(10, 0, 32'h0012_0000, "R6");

    // R12: ignored writes
    for (int s = 11; s < 16; s++) step(1'b1, s, 0, 32'hFFFF_FFFF, s, 0, "R12");
    step(1'b0, 10, 0, 32'hFFFF_FFFF, 10, 0, "R12");
    step(1'b0, 0, 3, 32'h0BAD_0BAD, 0, 3, "R12");
    sweep("R12");

    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      int s;
      int rs;
      s  = $urandom_range(0, 15);
      rs = $urandom_range(0, 15);
      step(($urandom_range(0, 3) != 0), s, $urandom_range(0, 15), $urandom(),
           rs, $urandom_range(0, 15), tagFor(rs));
    end
    sweep("R11");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule